// File: doc/BRIEF.md
# MIDI Serial Port with Local and Expansion Paths

This block is a MIDI UART for a host that moves whole bytes. Host writes land in a transmit FIFO. Each byte taken from that FIFO goes two ways at once. It is framed and shifted out on the local MIDI output pin at the MIDI bit rate. In the same cycle it is offered on a parallel handoff port that carries it to a remote expansion unit.

Incoming bytes have two sources. The first is a local deserializer on the MIDI input pin, which oversamples the line. The second is a byte channel from the expansion unit, which delivers bytes that the remote side received, once per upload frame. Both sources feed one receive FIFO, which the host drains.

The host sees a five-bit status word. Three of its bits are sticky error flags, and the host clears them with a status-read strobe.

Top module: `midi_uart`

## Requirements
- R1: The transmit FIFO holds 8 bytes. A write (`wr_i`) while `status_o[1]` (transmit full) is 1 is ignored, even if a byte leaves the FIFO in the same cycle.
- R2: The serial output idles high. Each frame is a 0 start bit, then 8 data bits LSB first, then a 1 stop bit. Every bit lasts 16 ticks, and one tick occurs every CLK_HZ/(BAUD*16) clocks.
- R3: Every byte that leaves the transmit FIFO is shown on `rem_tx_data_o` with a one-cycle `rem_tx_valid_o` pulse. The start bit of the same byte appears on `midi_o` in the next cycle. Bytes leave in write order.
- R4: A local serial byte is accepted only if the line is still low at the middle of the start bit. Its data bits are sampled at mid-bit, and an accepted byte is written into the receive FIFO.
- R5: A local frame whose stop bit reads 0 is dropped and sets the sticky framing flag `status_o[4]`.
- R6: Each cycle with `rem_rx_valid_i` high writes `rem_rx_data_i` into the receive FIFO.
- R7: When a local byte and a remote byte arrive in the same cycle, the local byte is stored, the remote byte is dropped, and the sticky collision flag `status_o[3]` is set.
- R8: The receive FIFO holds 23 bytes. A byte that arrives while it is full is dropped and sets the sticky overflow flag `status_o[2]`.
- R9: `rdata_o` shows the oldest receive byte, and `status_o[0]` is 1 when the receive FIFO is not empty. `rd_i` removes that byte. A read while the FIFO is empty has no effect.
- R10: A cycle with `stat_rd_i` high clears `status_o[4:2]`. An error event in that same cycle leaves its flag set.
- R11: After reset, `status_o` is 0, `midi_o` is 1 and `rem_tx_valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe into the transmit FIFO |
| wdata_i | input | 8 | Host write byte |
| rd_i | input | 1 | Host read strobe that pops the receive FIFO |
| rdata_o | output | 8 | Oldest receive byte |
| stat_rd_i | input | 1 | Status read strobe; clears the sticky flags |
| status_o | output | 5 | {framing, collision, overflow, tx full, rx available} |
| midi_i | input | 1 | Local serial MIDI input |
| midi_o | output | 1 | Local serial MIDI output |
| rem_tx_valid_o | output | 1 | Transmit byte handed to the expansion path |
| rem_tx_data_o | output | 8 | Byte handed to the expansion path |
| rem_rx_valid_i | input | 1 | Byte delivered by the expansion path |
| rem_rx_data_i | input | 8 | Expansion receive byte |

## Verification
The transmit path is tested with single bytes that have alternating, lowest-only and highest-only bits set. It is then tested with a burst longer than the FIFO. The single bytes catch bit-order and bit-width faults on the pin and on the handoff port. The burst shows whether writes to a full FIFO are really dropped.

On the receive side the tests are:
- a remote byte stream;
- a clean local frame;
- a frame with a low stop bit;
- a local frame whose arrival cycle is matched exactly by a remote byte;
- a remote burst of 25 bytes.

These separate the two input sources, the priority rule between them, and the overflow and sticky-clear rules. The burst also includes a status read that lands in the same cycle as a new overflow.

// File: rtl/midi_pkg.sv
package midi_pkg;
  localparam int OVS = 16;
  localparam int SW  = $clog2(OVS);
  localparam int DW  = 8;

  localparam int ST_AVAIL = 0;
  localparam int ST_TXFUL = 1;
  localparam int ST_OVF   = 2;
  localparam int ST_COL   = 3;
  localparam int ST_FERR  = 4;
  localparam int STW      = 5;

  typedef enum logic [2:0] {
    RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_HOLD
  } rx_state_e;
endpackage

// File: rtl/midi_fifo.sv
module midi_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int AW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign dout_o  = mem[rp];

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/midi_tx.sv
module midi_tx
  import midi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          avail_i,
  input  logic [DW-1:0] din_i,
  output logic          pop_o,
  output logic          midi_o
);
  logic          busy;
  logic [DW+1:0] shf;
  logic [3:0]    bit_cnt;
  logic [SW-1:0] sub;

  // frames start only on a tick so every bit is exactly OVS ticks wide
  assign pop_o  = ~busy & tick_i & avail_i;
  assign midi_o = busy ? shf[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy    <= 1'b0;
      shf     <= '1;
      bit_cnt <= '0;
      sub     <= '0;
    end else if (pop_o) begin
      busy    <= 1'b1;
      shf     <= {1'b1, din_i, 1'b0};
      bit_cnt <= '0;
      sub     <= '0;
    end else if (busy && tick_i) begin
      if (sub == SW'(OVS - 1)) begin
        sub <= '0;
        shf <= {1'b1, shf[DW+1:1]};
        if (bit_cnt == 4'(DW + 1)) busy <= 1'b0;
        else                       bit_cnt <= bit_cnt + 1'b1;
      end else begin
        sub <= sub + 1'b1;
      end
    end
  end
endmodule

// File: rtl/midi_rx.sv
module midi_rx
  import midi_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rx_i,
  output logic          vld_o,
  output logic          ferr_o,
  output logic [DW-1:0] data_o
);
  rx_state_e     st;
  logic [SW-1:0] sub;
  logic [2:0]    bit_cnt;
  logic          last_sub;

  assign last_sub = (sub == SW'(OVS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= RX_IDLE;
      sub     <= '0;
      bit_cnt <= '0;
      data_o  <= '0;
      vld_o   <= 1'b0;
      ferr_o  <= 1'b0;
    end else begin
      vld_o  <= 1'b0;
      ferr_o <= 1'b0;
      case (st)
        RX_IDLE: if (tick_i && !rx_i) begin
          st  <= RX_START;
          sub <= '0;
        end
        RX_START: if (tick_i) begin
          if (sub == SW'(OVS / 2 - 1)) begin
            sub     <= '0;
            bit_cnt <= '0;
            st      <= rx_i ? RX_IDLE : RX_DATA;  // glitch rejection
          end else sub <= sub + 1'b1;
        end
        RX_DATA: if (tick_i) begin
          if (last_sub) begin
            sub    <= '0;
            data_o <= {rx_i, data_o[DW-1:1]};
            if (bit_cnt == 3'(DW - 1)) st <= RX_STOP;
            else                       bit_cnt <= bit_cnt + 1'b1;
          end else sub <= sub + 1'b1;
        end
        RX_STOP: if (tick_i) begin
          if (last_sub) begin
            sub <= '0;
            if (rx_i) begin
              vld_o <= 1'b1;
              st    <= RX_IDLE;
            end else begin
              ferr_o <= 1'b1;
              st     <= RX_HOLD;
            end
          end else sub <= sub + 1'b1;
        end
        RX_HOLD: if (rx_i) st <= RX_IDLE;
        default: st <= RX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/midi_uart.sv
module midi_uart
  import midi_pkg::*;
#(
  parameter int CLK_HZ   = 50_000_000,
  parameter int BAUD     = 31_250,
  parameter int TX_DEPTH = 8,
  parameter int RX_DEPTH = 23
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           rd_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           stat_rd_i,
  output logic [STW-1:0] status_o,
  input  logic           midi_i,
  output logic           midi_o,
  output logic           rem_tx_valid_o,
  output logic [DW-1:0]  rem_tx_data_o,
  input  logic           rem_rx_valid_i,
  input  logic [DW-1:0]  rem_rx_data_i
);
  localparam int TICK_DIV = CLK_HZ / (BAUD * OVS);
  localparam int TW       = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;

  logic [TW-1:0] tcnt;
  logic          tick;
  logic [1:0]    sync_q;
  logic          tx_full, tx_empty, tx_pop;
  logic [DW-1:0] tx_head;
  logic          loc_vld, loc_ferr;
  logic [DW-1:0] loc_data;
  logic          rx_push, rx_full, rx_empty;
  logic [DW-1:0] rx_din;
  logic          ovf_q, col_q, ferr_q;

  assign tick = (tcnt == TW'(TICK_DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tcnt   <= '0;
      sync_q <= 2'b11;
    end else begin
      tcnt   <= tick ? '0 : tcnt + 1'b1;
      sync_q <= {sync_q[0], midi_i};
    end
  end

  midi_fifo #(.W(DW), .DEPTH(TX_DEPTH)) i_tx_fifo (
    .clk_i, .rst_ni,
    .push_i (wr_i),
    .din_i  (wdata_i),
    .pop_i  (tx_pop),
    .dout_o (tx_head),
    .full_o (tx_full),
    .empty_o(tx_empty)
  );

  midi_tx i_tx (
    .clk_i, .rst_ni,
    .tick_i (tick),
    .avail_i(~tx_empty),
    .din_i  (tx_head),
    .pop_o  (tx_pop),
    .midi_o (midi_o)
  );

  assign rem_tx_valid_o = tx_pop;
  assign rem_tx_data_o  = tx_head;

  midi_rx i_rx (
    .clk_i, .rst_ni,
    .tick_i(tick),
    .rx_i  (sync_q[1]),
    .vld_o (loc_vld),
    .ferr_o(loc_ferr),
    .data_o(loc_data)
  );

  // local deserializer wins a same-cycle clash with the expansion channel
  assign rx_push = loc_vld | rem_rx_valid_i;
  assign rx_din  = loc_vld ? loc_data : rem_rx_data_i;

  midi_fifo #(.W(DW), .DEPTH(RX_DEPTH)) i_rx_fifo (
    .clk_i, .rst_ni,
    .push_i (rx_push),
    .din_i  (rx_din),
    .pop_i  (rd_i),
    .dout_o (rdata_o),
    .full_o (rx_full),
    .empty_o(rx_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ovf_q  <= 1'b0;
      col_q  <= 1'b0;
      ferr_q <= 1'b0;
    end else begin
      ovf_q  <= (ovf_q & ~stat_rd_i) | (rx_push & rx_full);
      col_q  <= (col_q & ~stat_rd_i) | (loc_vld & rem_rx_valid_i);
      ferr_q <= (ferr_q & ~stat_rd_i) | loc_ferr;
    end
  end

  always_comb begin
    status_o           = '0;
    status_o[ST_AVAIL] = ~rx_empty;
    status_o[ST_TXFUL] = tx_full;
    status_o[ST_OVF]   = ovf_q;
    status_o[ST_COL]   = col_q;
    status_o[ST_FERR]  = ferr_q;
  end
endmodule

// File: rtl/midi_uart_chk.sv
module midi_uart_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_i,
  input logic       rd_i,
  input logic       stat_rd_i,
  input logic       rem_rx_valid_i,
  input logic       midi_o,
  input logic       rem_tx_valid_o,
  input logic [7:0] rdata_o,
  input logic [4:0] status_o,
  input logic       loc_vld,
  input logic       loc_ferr,
  input logic       rx_full
);
  AST_TX_START_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rem_tx_valid_o |=> !midi_o); // R3

  AST_TX_FULL_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[1] && wr_i && !rem_tx_valid_o |=> status_o[1]); // R1

  AST_COLLIDE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loc_vld && rem_rx_valid_i |=> status_o[3]); // R7

  AST_OVERFLOW_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_vld || rem_rx_valid_i) && rx_full |=> status_o[2]); // R8

  AST_FERR_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && !loc_ferr |=> !status_o[4]); // R10

  AST_HEAD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[0] && !rd_i |=> $stable(rdata_o)); // R9
endmodule

bind midi_uart midi_uart_chk i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_i          (wr_i),
  .rd_i          (rd_i),
  .stat_rd_i     (stat_rd_i),
  .rem_rx_valid_i(rem_rx_valid_i),
  .midi_o        (midi_o),
  .rem_tx_valid_o(rem_tx_valid_o),
  .rdata_o       (rdata_o),
  .status_o      (status_o),
  .loc_vld       (loc_vld),
  .loc_ferr      (loc_ferr),
  .rx_full       (rx_full)
);

// File: tb/test_midi_uart.sv
`timescale 1ns/1ps
module test_midi_uart;
  localparam int CLK_HZ = 200_000_000;
  localparam int BAUD   = 6_250_000;
  localparam int TDIV   = CLK_HZ / (BAUD * 16);
  localparam int BITC   = 16 * TDIV;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       wr_i = 0, rd_i = 0, stat_rd_i = 0, midi_i = 1;
  logic [7:0] wdata_i = 0, rem_rx_data_i = 0;
  logic       rem_rx_valid_i = 0;
  logic [7:0] rdata_o, rem_tx_data_o;
  logic [4:0] status_o;
  logic       midi_o, rem_tx_valid_o;

  always #2.5 clk = ~clk;

  midi_uart #(.CLK_HZ(CLK_HZ), .BAUD(BAUD)) i_midi_uart (
    .clk_i(clk), .rst_ni, .wr_i, .wdata_i, .rd_i, .rdata_o, .stat_rd_i, .status_o,
    .midi_i, .midi_o, .rem_tx_valid_o, .rem_tx_data_o, .rem_rx_valid_i, .rem_rx_data_i
  );

  int checks = 0, errors = 0, cyc = 0, tx_sent = 0;
  logic [7:0] tq[$], sq[$], rq[$];
  bit m_ovf = 0, m_col = 0, m_ferr = 0;
  bit local_busy = 0, loc_now = 0, done = 0;
  logic [7:0] loc_byte = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference, updated on pre-edge values
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst_ni) begin
      if (wr_i && tq.size() < 8) tq.push_back(wdata_i);
      if (rem_tx_valid_o) begin
        chk(tq.size() > 0 && rem_tx_data_o == tq[0], "R3", rem_tx_data_o, tq.size() > 0 ? tq[0] : 8'hxx);
        if (tq.size() > 0) sq.push_back(tq.pop_front());
        tx_sent++;
      end
      begin
        bit full;
        full = (rq.size() == 23);
        if (stat_rd_i) begin m_ovf = 0; m_col = 0; m_ferr = 0; end
        if (rd_i && rq.size() > 0) void'(rq.pop_front());
        if (loc_now) begin
          if (full) m_ovf = 1; else rq.push_back(loc_byte);
          if (rem_rx_valid_i) m_col = 1;
        end else if (rem_rx_valid_i) begin
          if (full) m_ovf = 1; else rq.push_back(rem_rx_data_i);
        end
      end
    end
  end

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    if (rst_ni && !done) begin
      chk(status_o[1] == (tq.size() == 8), "R1 tx_full", status_o[1], tq.size() == 8);
      if (!local_busy) begin
        chk(status_o[0] == (rq.size() > 0), "R9 avail", status_o[0], rq.size() > 0);
        if (rq.size() > 0) chk(rdata_o == rq[0], "R9 rdata", rdata_o, rq[0]);
        chk(status_o[2] == m_ovf, "R8 ovf", status_o[2], m_ovf);
        chk(status_o[3] == m_col, "R7 col", status_o[3], m_col);
        chk(status_o[4] == m_ferr, "R5 ferr", status_o[4], m_ferr);
      end
    end
  end

  // serial decoder on midi_o
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && midi_o == 1'b0) begin
        logic [7:0] b;
        repeat (BITC / 2 - 1) @(negedge clk);
        chk(midi_o == 1'b0, "R2 start", midi_o, 0);
        for (int i = 0; i < 8; i++) begin
          repeat (BITC) @(negedge clk);
          b[i] = midi_o;
        end
        repeat (BITC) @(negedge clk);
        chk(midi_o == 1'b1, "R2 stop", midi_o, 1);
        chk(sq.size() > 0 && b == sq[0], "R2 data", b, sq.size() > 0 ? sq[0] : 8'hxx);
        if (sq.size() > 0) void'(sq.pop_front());
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150_000);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog act=%0d exp=<150000", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic host_wr(input logic [7:0] b);
    wr_i = 1; wdata_i = b; @(negedge clk); wr_i = 0;
  endtask

  task automatic rem_in(input logic [7:0] b);
    rem_rx_valid_i = 1; rem_rx_data_i = b; @(negedge clk); rem_rx_valid_i = 0;
  endtask

  task automatic host_rd();
    rd_i = 1; @(negedge clk); rd_i = 0;
  endtask

  task automatic stat_rd();
    stat_rd_i = 1; @(negedge clk); stat_rd_i = 0;
  endtask

  task automatic send_ser(input logic [7:0] b, input bit good_stop, input bit mpush);
    logic [9:0] fr;
    local_busy = 1;
    fr = {good_stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      midi_i = fr[i];
      repeat (BITC) @(negedge clk);
    end
    midi_i = 1;
    repeat (8) @(negedge clk);
    if (mpush) begin
      if (good_stop) begin
        if (rq.size() == 23) m_ovf = 1; else rq.push_back(b);
      end else m_ferr = 1;
    end
    local_busy = 0;
  endtask

  initial begin
    int d, c0;
    repeat (3) @(negedge clk);
    chk(status_o == 5'b0, "R11 status", status_o, 0);
    chk(midi_o == 1'b1, "R11 midi_o", midi_o, 1);
    chk(rem_tx_valid_o == 1'b0, "R11 rem_tx", rem_tx_valid_o, 0);
    rst_ni = 1;
    repeat (4) @(negedge clk);

    // R2 R3: single bytes with distinct bit patterns
    host_wr(8'hA5); repeat (12 * BITC) @(negedge clk);
    host_wr(8'h01); repeat (12 * BITC) @(negedge clk);
    host_wr(8'h80); repeat (12 * BITC) @(negedge clk);

    // R1: burst of 11 writes, some must be dropped
    for (int i = 0; i < 11; i++) host_wr(8'h10 + 8'(i));
    chk(status_o[1] == 1'b1, "R1 full after burst", status_o[1], 1);
    repeat (12 * 11 * BITC) @(negedge clk);
    chk(tx_sent == 3 + 9, "R1 bytes sent", tx_sent, 12);
    chk(sq.size() == 0 && tq.size() == 0, "R3 all delivered", sq.size(), 0);

    // R6 R9: remote stream, then read back
    rem_in(8'h3A); rem_in(8'hC4); rem_in(8'h7F);
    chk(status_o[0] == 1'b1 && rdata_o == 8'h3A, "R6 remote head", rdata_o, 8'h3A);
    host_rd(); host_rd(); host_rd();
    chk(status_o[0] == 1'b0, "R9 empty", status_o[0], 0);
    host_rd();
    chk(status_o[0] == 1'b0, "R9 read empty ignored", status_o[0], 0);
    rem_in(8'h5E);
    chk(rdata_o == 8'h5E, "R9 empty read no pointer slip", rdata_o, 8'h5E);
    host_rd();

    // R4: local byte, measure arrival latency
    c0 = cyc; d = 0;
    fork
      send_ser(8'h3C, 1'b1, 1'b1);
      begin
        while (!status_o[0] && d < 2000) begin @(negedge clk); d++; end
      end
    join
    chk(rdata_o == 8'h3C && status_o[0], "R4 local byte", rdata_o, 8'h3C);
    host_rd();

    // R5 R10: framing error, then clear
    send_ser(8'h55, 1'b0, 1'b1);
    repeat (2 * BITC) @(negedge clk);
    chk(status_o[4] == 1'b1 && status_o[0] == 1'b0, "R5 ferr dropped", status_o, 5'h10);
    stat_rd(); m_ferr = 0;
    chk(status_o[4] == 1'b0, "R10 ferr cleared", status_o[4], 0);

    // R7: remote byte lands in the local arrival cycle
    repeat (2 * BITC) @(negedge clk);
    while (((cyc - c0) % TDIV) != 0) @(negedge clk);
    fork
      send_ser(8'h9B, 1'b1, 1'b0);
      begin
        repeat (d - 1) @(negedge clk);
        rem_rx_valid_i = 1; rem_rx_data_i = 8'hEE;
        loc_byte = 8'h9B; loc_now = 1;
        @(negedge clk);
        rem_rx_valid_i = 0; loc_now = 0;
      end
    join
    chk(status_o[3] == 1'b1, "R7 collision flag", status_o[3], 1);
    chk(rdata_o == 8'h9B, "R7 local kept", rdata_o, 8'h9B);
    host_rd();
    chk(status_o[0] == 1'b0, "R7 remote dropped", status_o[0], 0);
    stat_rd();

    // R8 R10: overflow and same-cycle set vs clear
    for (int i = 0; i < 25; i++) rem_in(8'h40 + 8'(i));
    chk(status_o[2] == 1'b1, "R8 overflow", status_o[2], 1);
    stat_rd_i = 1; rem_rx_valid_i = 1; rem_rx_data_i = 8'hFF;
    @(negedge clk);
    stat_rd_i = 0; rem_rx_valid_i = 0;
    chk(status_o[2] == 1'b1, "R10 set wins", status_o[2], 1);
    stat_rd();
    chk(status_o[2] == 1'b0, "R10 cleared", status_o[2], 0);
    for (int i = 0; i < 23; i++) begin
      chk(rdata_o == 8'h40 + 8'(i), "R8 stored order", rdata_o, 8'h40 + 8'(i));
      host_rd();
    end
    chk(status_o[0] == 1'b0, "R8 depth 23", status_o[0], 0);

    repeat (10) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule